// File: doc/BRIEF.md
# MSI Request Handshake Controller

This block turns interrupt events from surrounding logic into one-cycle MSI trigger pulses for a PCIe endpoint core. It never has more than one request outstanding. After each trigger it waits for the core to acknowledge with either a "sent" strobe or a "fail" strobe. Because a posted MSI write can still be reported as failed, a failure causes the same interrupt to be raised again after a short hold-off. Events that arrive while a request is in flight fold into a single latched flag. That flag produces exactly one more trigger once the current request has been sent.

The controller is built around four named states. IDLE waits for work. FIRE drives the trigger for exactly one cycle. WAIT_ACK (`ST_WAIT`) waits for the core's strobe. HOLDOFF (`ST_GAP`) pauses for `RETRY_GAP` cycles before a retry. The transitions are as follows:
- IDLE→FIRE happens on a new event or a latched flag.
- FIRE→WAIT_ACK happens unconditionally.
- WAIT_ACK→IDLE happens on sent.
- WAIT_ACK→HOLDOFF happens on fail without sent.
- HOLDOFF→FIRE happens when the hold-off count expires.

The controller also drives a pending-bit vector for the host, with 32 bits for each physical function. It drives a function select that always names function 0.

Top module: `msi_req_ctrl`

## Requirements
- R1: The trigger output is 32 bits wide. Only bit 0 may ever be 1; bits 31..1 are always 0.
- R2: Every trigger lasts exactly one cycle, so bit 0 is never 1 in two consecutive cycles.
- R3: After a trigger, no further trigger is raised until a sent or fail strobe arrives in a later cycle. Strobes that arrive during the trigger cycle, or while nothing is outstanding, are ignored.
- R4: A fail strobe, without sent, in a waiting cycle k leads to a re-trigger in cycle k+RETRY_GAP+1 (default RETRY_GAP=2). The trigger stays low in between.
- R5: The function-select output is always 0.
- R6: Pending bit 0 is 1 while a request is outstanding, in hold-off, or latched. It returns to 0 in the cycle after a sent strobe when nothing is latched. All other 63 pending bits are always 0.
- R7: Any number of events that arrive while busy are coalesced. A sent strobe in cycle k then yields exactly one new trigger, in cycle k+2.
- R8: When sent and fail arrive in the same waiting cycle, sent wins. There is no retry, and the controller returns to idle.
- R9: An event in idle (nothing latched or outstanding) yields a trigger in the next cycle.
- R10: During and right after reset, the trigger and the pending bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_req | input | 1 | Interrupt event request, sampled each cycle |
| ack_sent | input | 1 | Core strobe: MSI write was sent |
| ack_fail | input | 1 | Core strobe: MSI write failed |
| irq_trig | output | 32 | MSI trigger vector, bit 0 only |
| func_sel | output | 4 | Function select, fixed to 0 |
| pend_bits | output | 64 | Pending-status vector, 32 bits per function |

## Verification
The hardest situation to reach is an event landing in the exact cycle of a failure or of a simultaneous sent/fail pair. That event must survive the hold-off or the return to idle and yield exactly one extra trigger. The stimulus reaches it by driving the acknowledgement strobes from the bench at exact cycle offsets after each observed trigger. It raises events inside those same cycles, and it also sends stray strobes during the trigger cycle and in idle. A behavioural model follows every cycle and flags any extra, missing or mistimed pulse.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_WAIT = 2'd2,
        ST_GAP  = 2'd3
    } msi_st_e;
endpackage

// File: rtl/msi_evt_coalesce.sv
// Single-flag event latch: events seen while busy collapse into one flag.
module msi_evt_coalesce (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic busy_i,
    input  logic take_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (busy_i && evt_i) begin
            flag_q <= 1'b1;
        end else if (take_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/msi_seq_fsm.sv
// Request sequencer: IDLE -> FIRE -> WAIT -> (IDLE | GAP -> FIRE)
module msi_seq_fsm
    import msi_pkg::*;
#(
    parameter int RETRY_GAP = 2   // hold-off cycles before a retry, >= 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic flag_i,
    input  logic sent_i,
    input  logic fail_i,
    output logic fire_o,
    output logic busy_o,
    output logic take_o
);
    localparam int GAP_CW = (RETRY_GAP < 2) ? 1 : $clog2(RETRY_GAP + 1);
    localparam logic [GAP_CW-1:0] GAP_LIM = GAP_CW'(RETRY_GAP);
    localparam logic [GAP_CW-1:0] GAP_ONE = GAP_CW'(1);

    msi_st_e           state_q, state_d;
    logic [GAP_CW-1:0] gap_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (evt_i || flag_i) state_d = ST_FIRE;
            ST_FIRE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (sent_i)      state_d = ST_IDLE;
                else if (fail_i) state_d = ST_GAP;
            end
            ST_GAP:  if (gap_q >= GAP_LIM) state_d = ST_FIRE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and hold-off counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT && fail_i && !sent_i) begin
                gap_q <= GAP_ONE;
            end else if (state_q == ST_GAP) begin
                gap_q <= gap_q + GAP_ONE;
            end
        end
    end

    // outputs
    always_comb begin
        fire_o = 1'b0;
        busy_o = 1'b1;
        take_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                take_o = evt_i || flag_i;
            end
            ST_FIRE: fire_o = 1'b1;
            ST_WAIT: ;
            ST_GAP:  ;
            default: busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/msi_pend_map.sv
// Builds the per-function pending vector; only function 0 bit 0 is live.
module msi_pend_map #(
    parameter int NUM_FUNC      = 2,
    parameter int PEND_PER_FUNC = 32
) (
    input  logic                              active_i,
    output logic [NUM_FUNC*PEND_PER_FUNC-1:0] pend_o
);
    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        if (f == 0) begin : g_live
            assign pend_o[PEND_PER_FUNC-1:0] = PEND_PER_FUNC'(active_i);
        end else begin : g_idle
            assign pend_o[f*PEND_PER_FUNC +: PEND_PER_FUNC] = '0;
        end
    end
endmodule

// File: rtl/msi_req_ctrl.sv
module msi_req_ctrl #(
    parameter int TRIG_W        = 32,
    parameter int FUNC_W        = 4,
    parameter int NUM_FUNC      = 2,
    parameter int PEND_PER_FUNC = 32,
    parameter int RETRY_GAP     = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              evt_req,
    input  logic                              ack_sent,
    input  logic                              ack_fail,
    output logic [TRIG_W-1:0]                 irq_trig,
    output logic [FUNC_W-1:0]                 func_sel,
    output logic [NUM_FUNC*PEND_PER_FUNC-1:0] pend_bits
);
    logic fire, busy, take, flag;

    msi_evt_coalesce u_coal (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_req),
        .busy_i (busy),
        .take_i (take),
        .flag_o (flag)
    );

    msi_seq_fsm #(.RETRY_GAP(RETRY_GAP)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_req),
        .flag_i (flag),
        .sent_i (ack_sent),
        .fail_i (ack_fail),
        .fire_o (fire),
        .busy_o (busy),
        .take_o (take)
    );

    msi_pend_map #(.NUM_FUNC(NUM_FUNC), .PEND_PER_FUNC(PEND_PER_FUNC)) u_pend (
        .active_i (busy || flag),
        .pend_o   (pend_bits)
    );

    assign irq_trig = TRIG_W'(fire);
    assign func_sel = '0;
endmodule

// File: rtl/msi_req_ctrl_chk.sv
module msi_req_ctrl_chk #(
    parameter int TRIG_W = 32,
    parameter int FUNC_W = 4,
    parameter int PEND_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_req,
    input logic              ack_sent,
    input logic              ack_fail,
    input logic [TRIG_W-1:0] irq_trig,
    input logic [FUNC_W-1:0] func_sel,
    input logic [PEND_W-1:0] pend_bits
);
    logic out_q;   // a trigger has been issued and not yet acknowledged

    always_ff @(posedge clk) begin
        if (!rst_n)                      out_q <= 1'b0;
        else if (irq_trig[0])            out_q <= 1'b1;
        else if (ack_sent || ack_fail)   out_q <= 1'b0;
    end

    AST_UPPER_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (irq_trig >> 1) == '0); // R1
    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq_trig[0] |=> !irq_trig[0]); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) irq_trig[0] |-> !out_q); // R3
    AST_FAIL_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n) (out_q && ack_fail && !ack_sent) |=> !irq_trig[0]); // R4
    AST_FSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) func_sel == '0); // R5
    AST_PEND_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n) out_q |-> pend_bits[0]); // R6
    AST_PEND_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (pend_bits >> 1) == '0); // R6
    AST_SENT_WINS: assert property (@(posedge clk) disable iff (!rst_n) (out_q && ack_sent && ack_fail) |=> !irq_trig[0]); // R8
    AST_IDLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n) (!pend_bits[0] && evt_req) |=> irq_trig[0]); // R9
endmodule

bind msi_req_ctrl msi_req_ctrl_chk #(
    .TRIG_W (TRIG_W),
    .FUNC_W (FUNC_W),
    .PEND_W (NUM_FUNC*PEND_PER_FUNC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_req   (evt_req),
    .ack_sent  (ack_sent),
    .ack_fail  (ack_fail),
    .irq_trig  (irq_trig),
    .func_sel  (func_sel),
    .pend_bits (pend_bits)
);

// File: tb/tb_msi_req_ctrl.sv
`timescale 1ns/1ps
module tb_msi_req_ctrl;
    localparam int G = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_req = 1'b0, ack_sent = 1'b0, ack_fail = 1'b0;
    logic [31:0] irq_trig;
    logic [3:0]  func_sel;
    logic [63:0] pend_bits;

    int n_run = 0, n_fail = 0, cyc = 0, pulses = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    msi_req_ctrl #(.RETRY_GAP(G)) dut (
        .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .ack_sent(ack_sent),
        .ack_fail(ack_fail), .irq_trig(irq_trig), .func_sel(func_sel),
        .pend_bits(pend_bits)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 trigger, 2 awaiting ack, 3 hold-off
    int m_mode = 0, m_hold = 0;
    bit m_queued = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_mode = 0; m_queued = 0; m_hold = 0;
        end else begin
            if (m_mode == 0) begin
                if (evt_req || m_queued) begin m_mode = 1; m_queued = 0; end
            end else begin
                if (evt_req) m_queued = 1;
                if (m_mode == 1) m_mode = 2;
                else if (m_mode == 2) begin
                    if (ack_sent) m_mode = 0;
                    else if (ack_fail) begin m_mode = 3; m_hold = 1; end
                end else begin
                    if (m_hold >= G) m_mode = 1; else m_hold++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 model trig", irq_trig[0], m_mode == 1);
            check("R6 model pend", pend_bits[0], (m_mode != 0) || m_queued);
            check("R1 upper trig", irq_trig[31:1], 0);
            check("R5 func sel", func_sel, 0);
            check("R6 upper pend", pend_bits[63:1], 0);
            if (irq_trig[0]) pulses++;
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int p0;
        step(3);
        check("R10 reset trig", irq_trig, 0);
        check("R10 reset pend", pend_bits, 0);
        rst_n = 1'b1;
        step(2);
        check("R10 post-reset trig", irq_trig, 0);

        // R3 stray strobes in idle are ignored
        ack_sent = 1; ack_fail = 1; step(); ack_sent = 0; ack_fail = 0; step();
        check("R3 stray ack idle", {irq_trig[0], pend_bits[0]}, 0);

        // R9 idle event -> trigger next cycle
        evt_req = 1; step(); evt_req = 0;
        check("R9 trig after event", irq_trig[0], 1);
        // R3 fail during trigger cycle ignored
        ack_fail = 1; step(); ack_fail = 0;
        check("R3 ack in FIRE ignored", irq_trig[0], 0);
        step(3);
        check("R3 still waiting", irq_trig[0], 0);
        check("R6 pend while waiting", pend_bits[0], 1);
        ack_sent = 1; step(); ack_sent = 0;
        check("R6 pend cleared after sent", pend_bits[0], 0);
        step(2);
        check("R3 no trig after sent", irq_trig[0], 0);

        // R4 fail -> retry after G hold-off cycles
        evt_req = 1; step(); evt_req = 0; step(2);
        ack_fail = 1; step(); ack_fail = 0;
        for (int i = 0; i < G; i++) begin
            check("R4 hold-off low", irq_trig[0], 0);
            check("R6 pend in hold-off", pend_bits[0], 1);
            step();
        end
        check("R4 retry trig", irq_trig[0], 1);
        step();
        ack_sent = 1; step(); ack_sent = 0; step(3);

        // R7 coalescing: three events while busy -> one extra trigger
        p0 = pulses;
        evt_req = 1; step(); evt_req = 0;
        step(); evt_req = 1; step(); evt_req = 0; step();
        evt_req = 1; step(); evt_req = 0;
        ack_sent = 1; step(); ack_sent = 0;
        check("R7 idle cycle after sent", irq_trig[0], 0);
        step();
        check("R7 coalesced trig at k+2", irq_trig[0], 1);
        step(); ack_sent = 1; step(); ack_sent = 0; step(4);
        check("R7 total pulses", pulses - p0, 2);

        // event in same cycle as fail survives hold-off
        p0 = pulses;
        evt_req = 1; step(); evt_req = 0; step();
        ack_fail = 1; evt_req = 1; step(); ack_fail = 0; evt_req = 0;
        step(G);
        check("R4 retry with latched event", irq_trig[0], 1);
        step(); ack_sent = 1; step(); ack_sent = 0; step();
        check("R7 latched trig after sent", irq_trig[0], 1);
        step(); ack_sent = 1; step(); ack_sent = 0; step(4);
        check("R7 pulses with fail", pulses - p0, 3);

        // R8 both strobes together: sent wins
        p0 = pulses;
        evt_req = 1; step(); evt_req = 0; step();
        ack_sent = 1; ack_fail = 1; step(); ack_sent = 0; ack_fail = 0;
        check("R8 pend cleared", pend_bits[0], 0);
        step(G + 3);
        check("R8 no retry", pulses - p0, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule